// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

This block is a single up/down counter with a small register port. It either counts internal clock cycles, divided by a programmable prescaler, or it follows a two-phase quadrature encoder in one of three decoding functions. These are x2 on phase A alone, x2 on phase B alone, and x4 on both phases. The counter wraps at a programmable ceiling in both directions. Each wrap sets a sticky update flag and produces a one-cycle update pulse.

Software programs the block through a write strobe, an address and write data. Reads are combinational from the same address. Both encoder inputs are synchronised inside the block before their edges are detected. A software-forced update restarts the prescaler and reloads the counter so that new settings take effect from a known state.

Top module: `qdec_timer`

Register map (address: content):

- 0, control:
  - bit0 enable.
  - bit1 force update. Write 1 to trigger it; it reads back 1 only in the following cycle.
  - bit2 update flag. It reads 1 when set; writing 1 clears it.
  - bit3 direction. It is read-only and reads 1 when counting down.
- 1, function select in bits [1:0].
- 2, prescaler.
- 3, ceiling.
- 4, counter value.

## Requirements
- R1: After reset the counter reads 0, the ceiling reads all ones, the prescaler and function select read 0, and the control register reads 0.
- R2: With function 0, the counter increments once every P+1 enabled clock cycles, where P is the prescaler value, and the direction bit reads 0.
- R3: With function 1, each change of phase A moves the counter by one and phase B is ignored. The count goes up when, after the change, A differs from B, and down otherwise.
- R4: With function 2, each change of phase B moves the counter by one and phase A is ignored. The count goes up when, after the change, A equals B, and down otherwise.
- R5: With function 3, each change of either phase moves the counter by one, with the direction rules of R3 and R4. The direction bit holds the direction of the last counted move.
- R6: In any encoder function, a cycle in which both synchronised phases change together is ignored: the count and the direction are unchanged.
- R7: While the enable bit is 0, neither clock cycles nor encoder edges change the count or the direction.
- R8: Counting up from a value at or above the ceiling gives 0, sets the update flag and pulses the update output for one cycle.
- R9: Counting down from 0 gives the ceiling, sets the update flag and pulses the update output.
- R10: Writing 1 to the force-update bit has the following effects one cycle after the write:
  - The counter reloads to 0, or to the ceiling when the direction bit is 1.
  - The prescaler restarts.
  - The update flag is set and the update output pulses.
  - The force-update bit clears itself in the same cycle.
- R11: Writes to the ceiling and to the counter take effect on the next clock with no buffering.
- R12: Writing control with bit2 set clears the update flag unless a wrap or update sets it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for writes and reads |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for bus_addr (combinational) |
| phase_a | input | 1 | Encoder phase A (asynchronous) |
| phase_b | input | 1 | Encoder phase B (asynchronous) |
| upd_evt | output | 1 | One-cycle pulse on wrap or forced update |
| dir_o | output | 1 | Current direction, 1 = down |

## Verification
The bench builds the block with an 8-bit counter and a 4-bit prescaler. A small ceiling such as 5, 20 or 3 then makes wraps in both directions reachable within a handful of steps, and a prescaler value of 2 shows the divide-by-three behaviour within a dozen cycles. Encoder phases are held for six cycles per step, which covers the three-register path from pin to count. The bench walks full up and down quadrature cycles in every encoder function, including a simultaneous change of both phases. The update pulses are counted independently and compared with the number of wraps and forced updates.

// File: rtl/qdec_pkg.sv
// Shared types and register addresses for the quadrature timer counter.
package qdec_pkg;
    localparam int AW = 3;

    typedef enum logic [1:0] {
        FN_CLK = 2'd0,
        FN_X2A = 2'd1,
        FN_X2B = 2'd2,
        FN_X4  = 2'd3
    } qdec_fn_e;

    localparam logic [AW-1:0] ADR_CTRL = 3'd0;
    localparam logic [AW-1:0] ADR_FN   = 3'd1;
    localparam logic [AW-1:0] ADR_PSC  = 3'd2;
    localparam logic [AW-1:0] ADR_CEIL = 3'd3;
    localparam logic [AW-1:0] ADR_CNT  = 3'd4;

    localparam int B_EN   = 0;
    localparam int B_UG   = 1;
    localparam int B_FLAG = 2;
    localparam int B_DIR  = 3;
endpackage

// File: rtl/qdec_sync_edge.sv
// Synchroniser plus change detector for one asynchronous input.
// Assumes the input is slow compared with clk; chg is high for one
// cycle whenever the synchronised level differs from its previous value.
module qdec_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic chg
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    // Shift the raw input through the synchroniser and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign level = sh_q[STAGES-1];
    assign chg   = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/qdec_step_decode.sv
// Turns the selected counting function into a step request and a direction.
// Assumes synchronised phase levels and single-cycle change strobes.
module qdec_step_decode
    import qdec_pkg::*;
(
    input  qdec_fn_e fn,
    input  logic     en,
    input  logic     a_lvl,
    input  logic     b_lvl,
    input  logic     a_chg,
    input  logic     b_chg,
    output logic     evt,
    output logic     up
);
    logic a_only, b_only;

    assign a_only = a_chg & ~b_chg;
    assign b_only = b_chg & ~a_chg;

    // Select the event source and direction rule for the active function.
    always_comb begin
        evt = 1'b0;
        up  = 1'b1;
        unique case (fn)
            FN_CLK: begin
                evt = en;
                up  = 1'b1;
            end
            FN_X2A: begin
                evt = en & a_only;
                up  = a_lvl ^ b_lvl;
            end
            FN_X2B: begin
                evt = en & b_only;
                up  = ~(a_lvl ^ b_lvl);
            end
            FN_X4: begin
                evt = en & (a_only | b_only);
                up  = a_only ? (a_lvl ^ b_lvl) : ~(a_lvl ^ b_lvl);
            end
            default: begin
                evt = 1'b0;
                up  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/qdec_prescale.sv
// Divides count events by psc+1. Assumes restart has priority over evt.
module qdec_prescale #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          restart,
    input  logic [PW-1:0] psc,
    output logic          tick
);
    logic [PW-1:0] pcnt_q;
    logic          last;

    assign last = (pcnt_q >= psc);
    assign tick = evt & last & ~restart;

    // Advance the divider on each event; return to zero at the limit or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pcnt_q <= '0;
        end else if (evt) begin
            pcnt_q <= last ? '0 : pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/qdec_timer.sv
// Quadrature encoder timer counter: register file, up/down counter with
// wrap at the ceiling, update flag and forced update. Assumes PW <= CW and CW >= 4.
module qdec_timer
    import qdec_pkg::*;
#(
    parameter int CW      = 16,
    parameter int PW      = 16,
    parameter int SYNC_ST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    input  logic          phase_a,
    input  logic          phase_b,
    output logic          upd_evt,
    output logic          dir_o
);
    localparam int NPH = 2;

    logic           en_q, ug_q, flag_q, dir_q, upd_q;
    qdec_fn_e       fn_q;
    logic [PW-1:0]  psc_q;
    logic [CW-1:0]  ceil_q, cnt_q;
    logic [NPH-1:0] ph_in, ph_lvl, ph_chg;
    logic           evt, up, tick, wrap;
    logic           wr_ctrl, wr_fn, wr_psc, wr_ceil, wr_cnt;

    assign ph_in = {phase_b, phase_a};

    genvar g;
    generate
        for (g = 0; g < NPH; g++) begin : g_phase
            qdec_sync_edge #(.STAGES(SYNC_ST)) sync_i (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (ph_in[g]),
                .level (ph_lvl[g]),
                .chg   (ph_chg[g])
            );
        end
    endgenerate

    qdec_step_decode dec_i (
        .fn    (fn_q),
        .en    (en_q),
        .a_lvl (ph_lvl[0]),
        .b_lvl (ph_lvl[1]),
        .a_chg (ph_chg[0]),
        .b_chg (ph_chg[1]),
        .evt   (evt),
        .up    (up)
    );

    qdec_prescale #(.PW(PW)) psc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .restart (ug_q),
        .psc     (psc_q),
        .tick    (tick)
    );

    assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_fn   = bus_wr && (bus_addr == ADR_FN);
    assign wr_psc  = bus_wr && (bus_addr == ADR_PSC);
    assign wr_ceil = bus_wr && (bus_addr == ADR_CEIL);
    assign wr_cnt  = bus_wr && (bus_addr == ADR_CNT);

    assign wrap = tick && !ug_q && !wr_cnt &&
                  ((up && cnt_q >= ceil_q) || (!up && cnt_q == '0));

    // Configuration registers written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ug_q   <= 1'b0;
            fn_q   <= FN_CLK;
            psc_q  <= '0;
            ceil_q <= '1;
        end else begin
            ug_q <= wr_ctrl && bus_wdata[B_UG];
            if (wr_ctrl) en_q   <= bus_wdata[B_EN];
            if (wr_fn)   fn_q   <= qdec_fn_e'(bus_wdata[1:0]);
            if (wr_psc)  psc_q  <= bus_wdata[PW-1:0];
            if (wr_ceil) ceil_q <= bus_wdata;
        end
    end

    // Counter value: forced update, then bus write, then a prescaled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ug_q) begin
            cnt_q <= dir_q ? ceil_q : '0;
        end else if (wr_cnt) begin
            cnt_q <= bus_wdata;
        end else if (tick) begin
            if (up) cnt_q <= (cnt_q >= ceil_q) ? '0 : cnt_q + 1'b1;
            else    cnt_q <= (cnt_q == '0) ? ceil_q : cnt_q - 1'b1;
        end
    end

    // Direction follows the last counted encoder move; clock mode counts up.
    always_ff @(posedge clk) begin
        if (!rst_n || fn_q == FN_CLK) begin
            dir_q <= 1'b0;
        end else if (evt) begin
            dir_q <= ~up;
        end
    end

    // Update pulse and sticky flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            upd_q <= ug_q | wrap;
            if (ug_q || wrap) flag_q <= 1'b1;
            else if (wr_ctrl && bus_wdata[B_FLAG]) flag_q <= 1'b0;
        end
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL: begin
                bus_rdata[B_EN]   = en_q;
                bus_rdata[B_UG]   = ug_q;
                bus_rdata[B_FLAG] = flag_q;
                bus_rdata[B_DIR]  = dir_q;
            end
            ADR_FN:   bus_rdata = CW'(fn_q);
            ADR_PSC:  bus_rdata = CW'(psc_q);
            ADR_CEIL: bus_rdata = ceil_q;
            ADR_CNT:  bus_rdata = cnt_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign upd_evt = upd_q;
    assign dir_o   = dir_q;
endmodule

// File: rtl/qdec_timer_chk.sv
// Property checker for qdec_timer, attached by bind below.
module qdec_timer_chk
    import qdec_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [CW-1:0] bus_wdata,
    input logic          en_q,
    input logic          ug_q,
    input logic          dir_q,
    input logic [1:0]    fn_bits,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] ceil_q,
    input logic          tick,
    input logic          up,
    input logic          a_chg,
    input logic          b_chg,
    input logic          upd_evt
);
    logic cnt_wr, ug_wr;
    assign cnt_wr = bus_wr && (bus_addr == ADR_CNT);
    assign ug_wr  = bus_wr && (bus_addr == ADR_CTRL) && bus_wdata[B_UG];

    a_r2_clk_mode_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_bits == 2'd0) |=> !dir_q);

    a_r6_both_phases_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_bits != 2'd0 && a_chg && b_chg && !ug_q && !cnt_wr) |=> $stable(cnt_q));

    a_r7_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ug_q && !cnt_wr) |=> $stable(cnt_q));

    a_r8_wrap_up_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && up && !ug_q && !cnt_wr && cnt_q >= ceil_q) |=> (cnt_q == '0 && upd_evt));

    a_r9_wrap_down_to_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !up && !ug_q && !cnt_wr && cnt_q == '0) |=> (cnt_q == $past(ceil_q) && upd_evt));

    a_r10_update_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ug_q && !ug_wr) |=> !ug_q);

    a_r10_update_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        ug_q |=> upd_evt);
endmodule

bind qdec_timer qdec_timer_chk #(.CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_q      (en_q),
    .ug_q      (ug_q),
    .dir_q     (dir_q),
    .fn_bits   (fn_q),
    .cnt_q     (cnt_q),
    .ceil_q    (ceil_q),
    .tick      (tick),
    .up        (up),
    .a_chg     (ph_chg[0]),
    .b_chg     (ph_chg[1]),
    .upd_evt   (upd_evt)
);

// File: tb/qdec_timer_tb_top.sv
// Scoreboard bench: the driver queues expected values, the monitor compares.
`timescale 1ns/1ps
module qdec_timer_tb_top;
    localparam int CW = 8;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic          phase_a = 1'b0;
    logic          phase_b = 1'b0;
    logic          upd_evt;
    logic          dir_o;

    int total = 0;
    int bad = 0;
    int evt_cnt = 0;
    bit finished = 1'b0;

    typedef struct {
        int    kind;   // 0 = register, 1 = update pulse count, 2 = dir pin
        int    exp;
        string tag;
    } sb_t;
    sb_t sbq[$];

    always #2.5 clk = ~clk;

    qdec_timer #(.CW(CW), .PW(PW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .phase_a   (phase_a),
        .phase_b   (phase_b),
        .upd_evt   (upd_evt),
        .dir_o     (dir_o)
    );

    // Count update pulses just after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && upd_evt) evt_cnt++;
    end

    // Monitor: pop one expected item per falling edge and compare.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_t it;
            int  act;
            it  = sbq.pop_front();
            act = (it.kind == 0) ? int'(bus_rdata) : (it.kind == 1) ? evt_cnt : int'(dir_o);
            total++;
            if (act != it.exp) begin
                bad++;
                $display("FAIL %s actual=%0d expected=%0d", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = CW'(d);
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [2:0] a, input int e, input string tag);
        @(posedge clk);
        #1 bus_addr = a;
        sbq.push_back('{kind: kind, exp: e, tag: tag});
        @(negedge clk);
        #1;
    endtask

    task automatic ph(input logic a, input logic b);
        @(negedge clk);
        phase_a = a; phase_b = b;
        repeat (6) @(posedge clk);
    endtask

    task automatic run_en(input int m);
        wr(3'd0, 1);
        repeat (m) @(posedge clk);
        wr(3'd0, 0);
    endtask

    task automatic cyc_up();
        ph(1, 0); ph(1, 1); ph(0, 1); ph(0, 0);
    endtask

    task automatic cyc_dn();
        ph(0, 1); ph(1, 1); ph(1, 0); ph(0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        chk(0, 3'd0, 0,   "R1 ctrl");
        chk(0, 3'd4, 0,   "R1 count");
        chk(0, 3'd3, 255, "R1 ceiling");
        chk(0, 3'd2, 0,   "R1 prescaler");
        chk(0, 3'd1, 0,   "R1 function");

        // R2: clock mode, divide by one: 10 enabled edges
        run_en(9);
        chk(0, 3'd4, 10, "R2 count psc0");
        chk(2, 3'd0, 0,  "R2 dir pin");

        // R10 + R2: restart via forced update, then divide by three over 12 edges
        wr(3'd2, 2);
        wr(3'd0, 2);
        chk(0, 3'd4, 0, "R10 reload zero");
        chk(1, 3'd0, 1, "R10 pulse");
        run_en(11);
        chk(0, 3'd4, 4, "R2 count psc2");
        wr(3'd0, 4);
        chk(0, 3'd0, 0, "R12 flag cleared");

        // R8 + R11: wrap up at ceiling 5
        wr(3'd3, 5); wr(3'd2, 0); wr(3'd4, 3);
        run_en(3);
        chk(0, 3'd4, 1, "R8 wrapped count");
        chk(0, 3'd0, 4, "R8 flag set");
        chk(1, 3'd0, 2, "R8 pulse");
        wr(3'd0, 4);

        // R5: x4 decoding both ways
        wr(3'd3, 255); wr(3'd1, 3); wr(3'd4, 10); wr(3'd0, 1);
        cyc_up();
        chk(0, 3'd4, 14, "R5 x4 up");
        chk(0, 3'd0, 1,  "R5 dir up");
        cyc_dn();
        chk(0, 3'd4, 10, "R5 x4 down");
        chk(0, 3'd0, 9,  "R5 dir down");

        // R6: both phases together are ignored
        ph(1, 1); ph(0, 0);
        chk(0, 3'd4, 10, "R6 count held");
        chk(0, 3'd0, 9,  "R6 dir held");

        // R3: x2 on phase A
        wr(3'd1, 1);
        cyc_up();
        chk(0, 3'd4, 12, "R3 x2A up");
        chk(0, 3'd0, 1,  "R3 dir");

        // R4: x2 on phase B
        wr(3'd1, 2);
        cyc_up();
        chk(0, 3'd4, 14, "R4 x2B up");
        cyc_dn();
        chk(0, 3'd4, 12, "R4 x2B down");
        chk(0, 3'd0, 9,  "R4 dir down");

        // R9: wrap down at ceiling 20
        wr(3'd3, 20); wr(3'd4, 1); wr(3'd1, 3);
        cyc_dn();
        chk(0, 3'd4, 18, "R9 wrapped count");
        chk(0, 3'd0, 13, "R9 flag dir");
        chk(1, 3'd0, 3,  "R9 pulse");

        // R7: disabled, encoder moves ignored
        wr(3'd0, 4);
        cyc_up();
        chk(0, 3'd4, 18, "R7 count held");
        chk(0, 3'd0, 8,  "R7 ctrl");

        // R10: forced update while direction is down reloads the ceiling
        wr(3'd0, 2);
        chk(0, 3'd4, 20, "R10 reload ceiling");
        chk(0, 3'd0, 12, "R10 bit self-clear");
        chk(1, 3'd0, 4,  "R10 pulse");

        // R11: new ceiling applies at once in clock mode
        wr(3'd0, 4); wr(3'd1, 0); wr(3'd3, 3); wr(3'd4, 0);
        run_en(4);
        chk(0, 3'd4, 1, "R11 count");
        chk(1, 3'd0, 5, "R11 pulse");

        repeat (4) @(posedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule